// File: doc/BRIEF.md
# Clocked Serial Receive Channel with Error Lock

This block receives frames from a serial data pin that is clocked by an external serial clock. The serial clock and data are brought into the system clock domain by a synchronizer. Each rising edge of the serial clock samples one bit. A complete frame holds eight data bits, sent least significant bit first, then an even-parity bit, then a stop bit. When a frame completes without error, it is moved into a receive data register and a full flag is raised. The full flag can drive an interrupt.

Software uses a small register window. It can enable reception and the two interrupts, read the received byte, and inspect four status flags: full, overrun, framing error and parity error. A flag is cleared by writing 0 to it, but only after it has been read as 1. A DMA engine can take the byte from a dedicated output and pulse an acknowledge, which clears the full flag directly.

The receiver locks while any status flag is set. In that state it shifts bits but discards every frame. It starts transferring frames again once all flags have been cleared.

Top module: `sync_serial_rx`

## Requirements
- R1: A frame is 10 serial-clock rising edges: 8 data bits (least significant first), an even-parity bit (data plus parity has an even number of ones), and a stop bit that must be 1. Frames follow back to back from the moment reception is enabled. The received byte appears at `rx_data` and at register address 2.
- R2: A frame that ends while no flag is set, with correct parity and stop bit, loads the data register and sets the full flag (status bit 0).
- R3: While any status flag is set, a completing frame changes neither the data register nor the full, parity or framing flags.
- R4: If bit 7 of a frame is sampled while the full flag is 1, the overrun flag (status bit 1) is set and the data register keeps its old byte.
- R5: An unlocked frame with a stop bit of 0 sets the framing flag (status bit 2). An unlocked frame with wrong parity sets the parity flag (status bit 3). In both cases the data register and the full flag stay unchanged.
- R6: Writing 0 to a status bit (address 1) clears it only if that bit was read as 1 since it was last set. Writing 1, or writing 0 without such a read, has no effect.
- R7: A one-cycle pulse on `dma_ack` clears the full flag.
- R8: `irq_rx` is the full flag ANDed with control bit 1. `irq_err` is any of overrun, framing or parity ANDed with control bit 2.
- R9: Control bit 0 enables reception. While it is 0, the bit counter is held at the frame start, so a partial frame is discarded and the next frame after re-enabling starts fresh.
- R10: After reset, the control register, the status flags, the data register and both interrupts are 0.
- R11: Once every flag has been cleared, the next complete frame is transferred again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | External serial clock; data is sampled on its rising edge |
| sd_in | input | 1 | Serial data |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms status clearing) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| dma_ack | input | 1 | DMA read acknowledge; clears the full flag |
| rx_data | output | 8 | Receive data register |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
The hardest case to reach is a frame that arrives while the receiver is already locked. It needs a byte left unread, or an error left uncleared, while a whole further frame is clocked in. The bench sets this up with directed sequences: it leaves the full flag set through a second frame to produce an overrun, and it sends a good frame after a parity failure. It then checks that the data register kept the older byte. It also repeats random frames with injected parity and stop-bit faults, clearing the flags each time either through the read-then-write-zero sequence or through the DMA acknowledge.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic err_ie;
        logic rx_ie;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic perr;
        logic ferr;
        logic ovr;
        logic full;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_ok;
        logic              stop_ok;
    } frame_t;

    function automatic logic even_parity_ok(input logic [DATA_W-1:0] d, input logic p);
        return ~(^{d, p});
    endfunction
endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic sd_in,
    output logic rise,
    output logic sd_s
);
    logic [STAGES:0] sck_q;
    logic [STAGES-1:0] sd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q[0] <= 1'b0;
            sd_q[0]  <= 1'b0;
        end else begin
            sck_q[0] <= sck_in;
            sd_q[0]  <= sd_in;
        end
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_sck
        always_ff @(posedge clk) begin
            if (rst) sck_q[i] <= 1'b0;
            else     sck_q[i] <= sck_q[i-1];
        end
    end

    for (genvar j = 1; j < STAGES; j++) begin : g_sd
        always_ff @(posedge clk) begin
            if (rst) sd_q[j] <= 1'b0;
            else     sd_q[j] <= sd_q[j-1];
        end
    end

    assign rise = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sd_s = sd_q[STAGES-1];
endmodule

// File: rtl/sr_shifter.sv
module sr_shifter
    import sr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   sample,
    input  logic   bit_in,
    output logic   msb_seen,
    output logic   frame_done,
    output frame_t frame
);
    localparam logic [CNT_W-1:0] MSB_IDX  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(FRAME_BITS - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt        <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            msb_seen   <= 1'b0;
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            msb_seen   <= 1'b0;
            frame_done <= 1'b0;
            if (sample) begin
                if (cnt < PAR_IDX) begin
                    shreg <= {bit_in, shreg[DATA_W-1:1]};
                end
                if (cnt == MSB_IDX) msb_seen <= 1'b1;
                if (cnt == PAR_IDX) par_bit <= bit_in;
                if (cnt == STOP_IDX) begin
                    cnt            <= '0;
                    frame_done     <= 1'b1;
                    frame.data     <= shreg;
                    frame.par_ok   <= even_parity_ok(shreg, par_bit);
                    frame.stop_ok  <= bit_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sr_regs.sv
module sr_regs
    import sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              dma_ack,
    input  logic              msb_seen,
    input  logic              frame_done,
    input  frame_t            frame,
    output ctrl_t             ctrl,
    output flags_t            flags,
    output logic              lock,
    output logic [DATA_W-1:0] rdr
);
    flags_t flags_set, flags_clr, flags_nxt, armed;
    logic   unused_hi;

    assign unused_hi = ^wdata[7:4];
    assign lock      = |flags;

    always_comb begin
        flags_set      = '0;
        flags_set.ovr  = msb_seen & flags.full;
        if (frame_done && !lock) begin
            flags_set.full = frame.par_ok & frame.stop_ok;
            flags_set.perr = ~frame.par_ok;
            flags_set.ferr = ~frame.stop_ok;
        end
        flags_clr = '0;
        if (wr_en && addr == A_STAT) flags_clr = armed & ~flags_t'(wdata[3:0]);
        if (dma_ack) flags_clr.full = 1'b1;
        flags_nxt = (flags & ~flags_clr) | flags_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            flags <= '0;
            armed <= '0;
            rdr   <= '0;
        end else begin
            if (wr_en && addr == A_CTRL) ctrl <= ctrl_t'(wdata[2:0]);
            flags <= flags_nxt;
            armed <= (armed | ((rd_en && addr == A_STAT) ? flags : '0))
                     & ~flags_clr & ~flags_set & flags_nxt;
            if (flags_set.full) rdr <= frame.data;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = {5'd0, ctrl};
            A_STAT:  rdata = {4'd0, flags};
            A_DATA:  rdata = rdr;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import sr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_in,
    input  logic       sd_in,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       dma_ack,
    output logic [7:0] rx_data,
    output logic       irq_rx,
    output logic       irq_err
);
    logic   rise, sd_s, msb_seen, frame_done, lock;
    frame_t frame;
    ctrl_t  ctrl;
    flags_t flags;
    logic [DATA_W-1:0] rdr;

    sr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sck_in(sck_in), .sd_in(sd_in),
        .rise(rise), .sd_s(sd_s)
    );

    sr_shifter u_shift (
        .clk(clk), .rst(rst), .en(ctrl.rx_en), .sample(rise), .bit_in(sd_s),
        .msb_seen(msb_seen), .frame_done(frame_done), .frame(frame)
    );

    sr_regs u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .dma_ack(dma_ack), .msb_seen(msb_seen),
        .frame_done(frame_done), .frame(frame), .ctrl(ctrl), .flags(flags),
        .lock(lock), .rdr(rdr)
    );

    assign rx_data = rdr;
    assign irq_rx  = flags.full & ctrl.rx_ie;
    assign irq_err = (flags.ovr | flags.ferr | flags.perr) & ctrl.err_ie;
endmodule

// File: rtl/sr_rx_chk.sv
module sr_rx_chk
    import sr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input ctrl_t      ctrl,
    input flags_t     flags,
    input logic       frame_done,
    input logic       msb_seen,
    input logic [7:0] rx_data,
    input logic       irq_rx,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       dma_ack
);
    // R2
    full_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.full) |-> $past(frame_done));
    // R3
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && (flags != 4'd0)) |=> $stable(rx_data));
    // R4
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (msb_seen && flags.full) |=> (flags.ovr && $stable(rx_data)));
    // R6
    write_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd1 && wdata[3:0] == 4'hF && !dma_ack)
        |=> ((flags & $past(flags)) == $past(flags)));
    // R8
    irq_full_chk: assert property (@(posedge clk) disable iff (rst)
        irq_rx |-> flags.full);
    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.rx_en && $past(!ctrl.rx_en)) |-> !frame_done);
endmodule

bind sync_serial_rx sr_rx_chk u_chk (
    .clk(clk), .rst(rst), .ctrl(ctrl), .flags(flags), .frame_done(frame_done),
    .msb_seen(msb_seen), .rx_data(rx_data), .irq_rx(irq_rx), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .dma_ack(dma_ack)
);

// File: tb/tb_sync_serial_rx.sv
module tb_sync_serial_rx;
    logic clk = 0, rst = 1, sck_in = 0, sd_in = 0;
    logic [1:0] addr = 0;
    logic wr_en = 0, rd_en = 0, dma_ack = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata, rx_data;
    logic irq_rx, irq_err;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    sync_serial_rx dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic send_bit(input logic b);
        sd_in = b; repeat (4) @(negedge clk);
        sck_in = 1; repeat (8) @(negedge clk);
        sck_in = 0; repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input bit par_good, input bit stop_good);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        send_bit(par_good ? ^d : ~^d);
        send_bit(stop_good);
    endtask

    function automatic logic [7:0] st(input bit full, ovr, ferr, perr);
        return {4'd0, perr, ferr, ovr, full};
    endfunction

    task automatic clear_all();
        logic [7:0] s;
        rd(2'd1, s);
        wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, exp_data;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        rd(2'd0, r); chk("R10 ctrl", r, 0);
        rd(2'd1, r); chk("R10 status", r, 0);
        chk("R10 data", rx_data, 0);
        chk("R10 irqs", {irq_rx, irq_err}, 0);

        wr(2'd0, 8'h07);
        // R1 R2 basic frame
        send_frame(8'hA5, 1, 1);
        rd(2'd1, r); chk("R2 full set", r, st(1, 0, 0, 0));
        rd(2'd2, r); chk("R1 data reg", r, 8'hA5);
        chk("R8 irq_rx", irq_rx, 1);
        // R6 write 1 no effect
        wr(2'd1, 8'hFF);
        rd(2'd1, r); chk("R6 write one", r, st(1, 0, 0, 0));
        // R4 overrun: second frame while full
        send_frame(8'h3C, 1, 1);
        rd(2'd1, r); chk("R4 overrun flag", r, st(1, 1, 0, 0));
        chk("R4 data kept", rx_data, 8'hA5);
        chk("R8 irq_err", irq_err, 1);
        // R3 locked frame ignored
        wr(2'd1, 8'h00);
        rd(2'd1, r); chk("R6 clear after read", r, 0);
        // R6 write 0 without read
        send_frame(8'h11, 1, 1);
        rd(2'd2, r); chk("R11 resume", r, 8'h11);
        @(negedge clk); addr = 2'd1; wdata = 8'h00; wr_en = 1;
        @(negedge clk); wr_en = 0;
        chk("R6 no read no clear", rx_data == 8'h11 && dut.irq_rx, 1);
        // R7 dma ack
        @(negedge clk); dma_ack = 1; @(negedge clk); dma_ack = 0;
        rd(2'd1, r); chk("R7 dma clears full", r, 0);
        // R5 parity error then R3 lock
        send_frame(8'h5A, 0, 1);
        rd(2'd1, r); chk("R5 parity flag", r, st(0, 0, 0, 1));
        chk("R5 data unchanged", rx_data, 8'h11);
        send_frame(8'h77, 1, 1);
        rd(2'd1, r); chk("R3 locked status", r, st(0, 0, 0, 1));
        chk("R3 locked data", rx_data, 8'h11);
        wr(2'd1, 8'h00);
        send_frame(8'hF0, 1, 0);
        rd(2'd1, r); chk("R5 framing flag", r, st(0, 0, 1, 0));
        clear_all();
        // R8 irq enable off
        wr(2'd0, 8'h01);
        send_frame(8'h99, 1, 1);
        chk("R8 irq masked", {irq_rx, irq_err}, 0);
        chk("R11 data after clear", rx_data, 8'h99);
        clear_all();
        // R9 partial frame then disable
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h07);
        send_frame(8'h42, 1, 1);
        chk("R9 fresh frame", rx_data, 8'h42);
        clear_all();
        exp_data = 8'h42;
        // random frames
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d;
            int kind;
            d = 8'($urandom);
            kind = $urandom % 5;
            send_frame(d, kind != 0, kind != 1);
            if (kind >= 2) exp_data = d;
            rd(2'd1, r);
            chk("R2 R5 random status", r,
                st(kind >= 2, 0, kind == 1, kind == 0));
            chk("R1 random data", rx_data, exp_data);
            if (kind >= 2 && n[0]) begin
                @(negedge clk); dma_ack = 1; @(negedge clk); dma_ack = 0;
            end else begin
                wr(2'd1, 8'h00);
            end
            rd(2'd1, r); chk("R6 R7 random clear", r, 0);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule